// File: doc/BRIEF.md
# Optical Disc Controller Host Register Port

This block is the byte-wide register port through which a host processor talks to an optical disc drive controller. The host chooses a register with a small address, strobes a read or a write, and moves one byte per cycle. Behind the port sit three byte queues: parameters going to the drive, responses coming back from it, and sector data coming back from it. The port also holds a live status byte built from the queue fill levels and the engine state, a drive status byte, an interrupt enable mask, an interrupt type code, and one interrupt request line.

A small command engine takes each command byte written by the host. It answers the drive status query by queuing the drive status byte. It answers the test command, when its subcommand asks for the firmware version, by queuing four version bytes. Every answer ends by posting interrupt type 3. The engine stays busy for a few cycles per command and refuses new command bytes until it is idle again. All other command codes are accepted and then dropped. Sector data enters the data queue from the drive side on a separate push strobe.

Top module: `disc_host_if`

## Requirements
- R1: After reset the status byte reads 0x18, the interrupt enable reads 0x1F, the interrupt type reads 0, the interrupt line is low, all queues are empty, and the drive status byte is 0x10 (only the door-open bit 4 set).
- R2: The status byte (read address 0) holds bit 7 = engine busy, bit 6 = data queue not empty, bit 5 = response queue not empty, bit 4 = parameter queue not full, bit 3 = parameter queue empty, and reads 0 in bits 2 to 0. It follows every queue push, pop and clear and every command.
- R3: A read of address 1 pops the response queue and a read of address 2 pops the data queue, both in arrival order. A pop of an empty queue returns 0x00 and changes nothing.
- R4: Each queue holds DEPTH bytes (16 by default). A push into a full queue is dropped.
- R5: Command byte 0x01 written to address 1 queues the drive status byte as one response and sets the interrupt type to 3. The type is only ever 0 or 3.
- R6: Command byte 0x19 pops one subcommand byte from the parameter queue. Subcommand 0x20 queues the responses 0x94, 0x09, 0x19, 0xC0 in that order, then empties the parameter queue and sets the interrupt type to 3.
- R7: Command 0x19 with any other subcommand, or with an empty parameter queue (read as 0x00), still consumes one parameter byte but queues nothing and leaves the interrupt type unchanged. Any command code other than 0x01 and 0x19 changes no queue and no interrupt state.
- R8: A command byte written while status bit 7 is 1 is ignored.
- R9: A write to address 3 loads the interrupt enable from bits 4 to 0; a read of address 3 returns it in bits 4 to 0. The interrupt line is high exactly when the interrupt type (read at address 4, bits 2 to 0) and the enable share a set bit.
- R10: A write to address 4 with any of bits 4 to 0 set clears the interrupt type to 0; a write with those bits zero has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| host_addr | input | 3 | Register address |
| host_rd | input | 1 | Read strobe; pops a queue at addresses 1 and 2 |
| host_wr | input | 1 | Write strobe |
| host_wdata | input | 8 | Write data |
| host_rdata | output | 8 | Read data for the addressed register, valid while host_rd is high |
| drv_push | input | 1 | Drive-side push into the data queue |
| drv_byte | input | 8 | Drive-side data byte |
| irq | output | 1 | Interrupt request |

## Verification
The bench builds the block with its default queue depth of 16. A depth that small lets short directed runs fill all three queues past capacity. It also lets the parameter queue reach full while the test command is pending, which shows the status not-full bit falling and the queue clear that ends a version reply. Random host traffic then mixes pushes, pops, commands, acknowledges and mask changes, so that wrap-around of every queue pointer and empty-queue pops happen many times within the run.

// File: rtl/disc_if_pkg.sv
package disc_if_pkg;

  // host read addresses
  localparam logic [2:0] RA_STATUS = 3'd0;
  localparam logic [2:0] RA_RESP   = 3'd1;
  localparam logic [2:0] RA_DATA   = 3'd2;
  localparam logic [2:0] RA_IEN    = 3'd3;
  localparam logic [2:0] RA_IFLAG  = 3'd4;

  // host write addresses
  localparam logic [2:0] WA_CMD    = 3'd1;
  localparam logic [2:0] WA_PARAM  = 3'd2;
  localparam logic [2:0] WA_IEN    = 3'd3;
  localparam logic [2:0] WA_ACK    = 3'd4;

  // command and subcommand codes
  localparam logic [7:0] CMD_STAT  = 8'h01;
  localparam logic [7:0] CMD_TEST  = 8'h19;
  localparam logic [7:0] SUB_VER   = 8'h20;

  localparam logic [2:0] IRQ_DONE  = 3'd3;
  localparam logic [4:0] IEN_RESET = 5'h1F;
  localparam logic [7:0] DRV_RESET = 8'h10;

  localparam int VER_LEN = 4;

  typedef enum logic [1:0] {
    ENG_IDLE,
    ENG_DECODE,
    ENG_SUB,
    ENG_REPLY
  } eng_state_t;

  function automatic logic [7:0] version_byte(input int idx);
    case (idx)
      0:       return 8'h94;
      1:       return 8'h09;
      2:       return 8'h19;
      default: return 8'hC0;
    endcase
  endfunction

endpackage

// File: rtl/disc_byte_fifo.sv
module disc_byte_fifo #(
  parameter int W     = 8,
  parameter int DEPTH = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              push,
  input  logic [W-1:0]      wdata,
  input  logic              pop,
  input  logic              clr,
  output logic [W-1:0]      rdata,
  output logic              empty,
  output logic              full,
  output logic [$clog2(DEPTH+1)-1:0] count
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);
  localparam logic [AW-1:0] LAST = AW'(DEPTH - 1);

  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] wp_q, wp_d, rp_q, rp_d;
  logic [CW-1:0] cnt_q, cnt_d;
  logic          do_push, do_pop;

  assign empty   = (cnt_q == '0);
  assign full    = (cnt_q == CW'(DEPTH));
  assign count   = cnt_q;
  assign do_push = push && !full && !clr;
  assign do_pop  = pop && !empty && !clr;
  assign rdata   = empty ? '0 : mem[rp_q];

  always_comb begin
    wp_d  = wp_q;
    rp_d  = rp_q;
    cnt_d = cnt_q;
    if (clr) begin
      wp_d  = '0;
      rp_d  = '0;
      cnt_d = '0;
    end else begin
      if (do_push) wp_d = (wp_q == LAST) ? '0 : wp_q + 1'b1;
      if (do_pop)  rp_d = (rp_q == LAST) ? '0 : rp_q + 1'b1;
      case ({do_push, do_pop})
        2'b10:   cnt_d = cnt_q + 1'b1;
        2'b01:   cnt_d = cnt_q - 1'b1;
        default: cnt_d = cnt_q;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wp_q  <= '0;
      rp_q  <= '0;
      cnt_q <= '0;
    end else begin
      wp_q  <= wp_d;
      rp_q  <= rp_d;
      cnt_q <= cnt_d;
    end
  end

  always_ff @(posedge clk) begin
    if (do_push) mem[wp_q] <= wdata;
  end

endmodule

// File: rtl/disc_cmd_engine.sv
module disc_cmd_engine
  import disc_if_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       cmd_wr,
  input  logic [7:0] cmd_byte,
  input  logic [7:0] prm_head,
  input  logic [7:0] drv_status,
  output logic       prm_pop,
  output logic       prm_clr,
  output logic       rsp_push,
  output logic [7:0] rsp_byte,
  output logic       irq_set,
  output logic [2:0] irq_code,
  output logic       busy,
  output eng_state_t state
);
  localparam int CNT_W = $clog2(VER_LEN);
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(VER_LEN - 1);

  eng_state_t       st_q, st_d;
  logic [7:0]       cmd_q, cmd_d;
  logic [7:0]       sub_q, sub_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;

  assign busy     = (st_q != ENG_IDLE);
  assign state    = st_q;
  assign irq_code = IRQ_DONE;

  always_comb begin
    st_d     = st_q;
    cmd_d    = cmd_q;
    sub_d    = sub_q;
    cnt_d    = cnt_q;
    prm_pop  = 1'b0;
    prm_clr  = 1'b0;
    rsp_push = 1'b0;
    rsp_byte = 8'h00;
    irq_set  = 1'b0;
    case (st_q)
      ENG_IDLE: begin
        if (cmd_wr) begin
          cmd_d = cmd_byte;
          st_d  = ENG_DECODE;
        end
      end
      ENG_DECODE: begin
        if (cmd_q == CMD_STAT) begin
          rsp_push = 1'b1;
          rsp_byte = drv_status;
          irq_set  = 1'b1;
          st_d     = ENG_IDLE;
        end else if (cmd_q == CMD_TEST) begin
          prm_pop = 1'b1;
          sub_d   = prm_head;
          st_d    = ENG_SUB;
        end else begin
          st_d = ENG_IDLE;
        end
      end
      ENG_SUB: begin
        cnt_d = '0;
        st_d  = (sub_q == SUB_VER) ? ENG_REPLY : ENG_IDLE;
      end
      ENG_REPLY: begin
        rsp_push = 1'b1;
        rsp_byte = version_byte(int'(cnt_q));
        if (cnt_q == CNT_LAST) begin
          prm_clr = 1'b1;
          irq_set = 1'b1;
          st_d    = ENG_IDLE;
        end else begin
          cnt_d = cnt_q + 1'b1;
        end
      end
      default: st_d = ENG_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q  <= ENG_IDLE;
      cmd_q <= '0;
      sub_q <= '0;
      cnt_q <= '0;
    end else begin
      st_q  <= st_d;
      cmd_q <= cmd_d;
      sub_q <= sub_d;
      cnt_q <= cnt_d;
    end
  end

endmodule

// File: rtl/disc_irq_regs.sv
module disc_irq_regs
  import disc_if_pkg::*;
#(
  parameter int EN_W   = 5,
  parameter int CODE_W = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ien_we,
  input  logic [EN_W-1:0]   ien_wdata,
  input  logic              ack_we,
  input  logic [EN_W-1:0]   ack_wdata,
  input  logic              set,
  input  logic [CODE_W-1:0] code,
  output logic [EN_W-1:0]   ien,
  output logic [CODE_W-1:0] flag,
  output logic              irq
);
  logic [EN_W-1:0]   ien_q, ien_d;
  logic [CODE_W-1:0] flag_q, flag_d;

  always_comb begin
    ien_d  = ien_we ? ien_wdata : ien_q;
    flag_d = flag_q;
    if (set)                 flag_d = code;
    else if (ack_we && |ack_wdata) flag_d = '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ien_q  <= IEN_RESET[EN_W-1:0];
      flag_q <= '0;
    end else begin
      ien_q  <= ien_d;
      flag_q <= flag_d;
    end
  end

  assign ien  = ien_q;
  assign flag = flag_q;
  assign irq  = |(EN_W'(flag_q) & ien_q);

endmodule

// File: rtl/disc_host_if.sv
module disc_host_if
  import disc_if_pkg::*;
#(
  parameter int DEPTH = 16
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [2:0] host_addr,
  input  logic       host_rd,
  input  logic       host_wr,
  input  logic [7:0] host_wdata,
  output logic [7:0] host_rdata,
  input  logic       drv_push,
  input  logic [7:0] drv_byte,
  output logic       irq
);
  localparam int CW = $clog2(DEPTH + 1);

  logic       rst_m, rst_sync_n;
  logic [7:0] drv_st_q, drv_st_d;

  logic       prm_push, prm_pop, prm_clr, prm_empty, prm_full;
  logic [7:0] prm_head;
  logic [CW-1:0] prm_count;

  logic       rsp_push, rsp_pop, rsp_empty, rsp_full;
  logic [7:0] rsp_byte, rsp_head;
  logic [CW-1:0] rsp_count;

  logic       dat_pop, dat_empty, dat_full;
  logic [7:0] dat_head;
  logic [CW-1:0] dat_count;

  logic       cmd_wr, eng_busy, irq_set;
  logic [2:0] irq_code, irq_flag;
  logic [4:0] irq_en;
  eng_state_t eng_state;
  logic [7:0] status;

  // reset: asynchronous assert, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_m      <= 1'b0;
      rst_sync_n <= 1'b0;
    end else begin
      rst_m      <= 1'b1;
      rst_sync_n <= rst_m;
    end
  end

  // drive status byte: held, no mechanics modelled
  assign drv_st_d = drv_st_q;
  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) drv_st_q <= DRV_RESET;
    else             drv_st_q <= drv_st_d;
  end

  assign cmd_wr   = host_wr && (host_addr == WA_CMD) && !eng_busy;
  assign prm_push = host_wr && (host_addr == WA_PARAM);
  assign rsp_pop  = host_rd && (host_addr == RA_RESP);
  assign dat_pop  = host_rd && (host_addr == RA_DATA);

  disc_byte_fifo #(.W(8), .DEPTH(DEPTH)) u_prm (
    .clk(clk), .rst_n(rst_sync_n), .push(prm_push), .wdata(host_wdata),
    .pop(prm_pop), .clr(prm_clr), .rdata(prm_head), .empty(prm_empty),
    .full(prm_full), .count(prm_count)
  );

  disc_byte_fifo #(.W(8), .DEPTH(DEPTH)) u_rsp (
    .clk(clk), .rst_n(rst_sync_n), .push(rsp_push), .wdata(rsp_byte),
    .pop(rsp_pop), .clr(1'b0), .rdata(rsp_head), .empty(rsp_empty),
    .full(rsp_full), .count(rsp_count)
  );

  disc_byte_fifo #(.W(8), .DEPTH(DEPTH)) u_dat (
    .clk(clk), .rst_n(rst_sync_n), .push(drv_push), .wdata(drv_byte),
    .pop(dat_pop), .clr(1'b0), .rdata(dat_head), .empty(dat_empty),
    .full(dat_full), .count(dat_count)
  );

  disc_cmd_engine u_eng (
    .clk(clk), .rst_n(rst_sync_n), .cmd_wr(cmd_wr), .cmd_byte(host_wdata),
    .prm_head(prm_head), .drv_status(drv_st_q), .prm_pop(prm_pop),
    .prm_clr(prm_clr), .rsp_push(rsp_push), .rsp_byte(rsp_byte),
    .irq_set(irq_set), .irq_code(irq_code), .busy(eng_busy), .state(eng_state)
  );

  disc_irq_regs #(.EN_W(5), .CODE_W(3)) u_irq (
    .clk(clk), .rst_n(rst_sync_n),
    .ien_we(host_wr && (host_addr == WA_IEN)), .ien_wdata(host_wdata[4:0]),
    .ack_we(host_wr && (host_addr == WA_ACK)), .ack_wdata(host_wdata[4:0]),
    .set(irq_set), .code(irq_code), .ien(irq_en), .flag(irq_flag), .irq(irq)
  );

  // live status, rebuilt from current fill state every cycle
  assign status = {eng_busy, !dat_empty, !rsp_empty, !prm_full, prm_empty, 3'b000};

  always_comb begin
    case (host_addr)
      RA_STATUS: host_rdata = status;
      RA_RESP:   host_rdata = rsp_head;
      RA_DATA:   host_rdata = dat_head;
      RA_IEN:    host_rdata = {3'b000, irq_en};
      RA_IFLAG:  host_rdata = {5'b00000, irq_flag};
      default:   host_rdata = 8'h00;
    endcase
  end

endmodule

// File: rtl/disc_host_if_checker.sv
module disc_host_if_checker
  import disc_if_pkg::*;
#(
  parameter int DEPTH = 16
) (
  input logic       clk,
  input logic       rst_sync_n,
  input logic [2:0] host_addr,
  input logic       host_rd,
  input logic       host_wr,
  input logic [7:0] host_wdata,
  input logic [7:0] host_rdata,
  input logic       drv_push,
  input logic       irq,
  input eng_state_t eng_state,
  input logic       irq_set,
  input logic [2:0] irq_flag,
  input logic [4:0] irq_en,
  input logic [$clog2(DEPTH+1)-1:0] prm_count,
  input logic [$clog2(DEPTH+1)-1:0] rsp_count,
  input logic [$clog2(DEPTH+1)-1:0] dat_count
);
  localparam int CW = $clog2(DEPTH + 1);

  assert_no_overflow_R4: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (prm_count <= CW'(DEPTH)) && (rsp_count <= CW'(DEPTH)) && (dat_count <= CW'(DEPTH)));

  assert_empty_pop_zero_R3: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (host_rd && host_addr == RA_DATA && dat_count == '0) |-> (host_rdata == 8'h00));

  assert_empty_pop_hold_R3: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (host_rd && host_addr == RA_DATA && dat_count == '0 && !drv_push) |=> (dat_count == '0));

  assert_busy_bit_R2: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (host_rd && host_addr == RA_STATUS) |->
      (host_rdata[7] == (eng_state != ENG_IDLE)) && (host_rdata[2:0] == 3'b000));

  assert_refuse_busy_R8: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (eng_state != ENG_IDLE && host_wr && host_addr == WA_CMD) |=> (eng_state != ENG_DECODE));

  assert_flag_code_R5: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (irq_flag == 3'd0) || (irq_flag == IRQ_DONE));

  assert_ack_clear_R10: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (host_wr && host_addr == WA_ACK && |host_wdata[4:0] && !irq_set) |=> (irq_flag == 3'd0));

  assert_masked_quiet_R9: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (irq_en == 5'd0) |-> !irq);

endmodule

bind disc_host_if disc_host_if_checker #(.DEPTH(DEPTH)) u_chk (
  .clk(clk), .rst_sync_n(rst_sync_n), .host_addr(host_addr), .host_rd(host_rd),
  .host_wr(host_wr), .host_wdata(host_wdata), .host_rdata(host_rdata),
  .drv_push(drv_push), .irq(irq), .eng_state(eng_state), .irq_set(irq_set),
  .irq_flag(irq_flag), .irq_en(irq_en), .prm_count(prm_count),
  .rsp_count(rsp_count), .dat_count(dat_count)
);

// File: tb/disc_host_if_test.sv
module disc_host_if_test;
  localparam int DEPTH = 16;

  logic       clk;
  logic       rst_n;
  logic [2:0] host_addr;
  logic       host_rd;
  logic       host_wr;
  logic [7:0] host_wdata;
  logic [7:0] host_rdata;
  logic       drv_push;
  logic [7:0] drv_byte;
  logic       irq;

  int n_cmp = 0;
  int n_bad = 0;
  bit finished = 0;

  logic [7:0] pq[$];
  logic [7:0] rq[$];
  logic [7:0] dq[$];
  logic [2:0] m_flag;
  logic [4:0] m_ien;

  disc_host_if #(.DEPTH(DEPTH)) uut (
    .clk(clk), .rst_n(rst_n), .host_addr(host_addr), .host_rd(host_rd),
    .host_wr(host_wr), .host_wdata(host_wdata), .host_rdata(host_rdata),
    .drv_push(drv_push), .drv_byte(drv_byte), .irq(irq)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  function automatic logic [7:0] exp_status(input logic busy);
    return {busy, dq.size() != 0, rq.size() != 0, pq.size() < DEPTH, pq.size() == 0, 3'b000};
  endfunction

  function automatic logic exp_irq();
    return |({2'b00, m_flag} & m_ien);
  endfunction

  function automatic logic [7:0] ver(input int i);
    case (i)
      0: return 8'h94;
      1: return 8'h09;
      2: return 8'h19;
      default: return 8'hC0;
    endcase
  endfunction

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %02h expected %02h", req, act, exp);
    end
  endtask

  task automatic rd(input logic [2:0] a, output logic [7:0] d);
    @(negedge clk);
    host_addr = a;
    host_rd = 1'b1;
    #1 d = host_rdata;
    @(posedge clk);
    #1 host_rd = 1'b0;
  endtask

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk);
    host_addr = a;
    host_wdata = d;
    host_wr = 1'b1;
    @(posedge clk);
    #1 host_wr = 1'b0;
  endtask

  task automatic dpush(input logic [7:0] d);
    @(negedge clk);
    drv_byte = d;
    drv_push = 1'b1;
    @(posedge clk);
    #1 drv_push = 1'b0;
    if (dq.size() < DEPTH) dq.push_back(d);
  endtask

  task automatic ppush(input logic [7:0] d);
    wr(3'd2, d);
    if (pq.size() < DEPTH) pq.push_back(d);
  endtask

  task automatic wait_idle();
    logic [7:0] s;
    for (int i = 0; i < 40; i++) begin
      rd(3'd0, s);
      if (!s[7]) break;
    end
  endtask

  task automatic model_cmd(input logic [7:0] c);
    logic [7:0] sub;
    if (c == 8'h01) begin
      if (rq.size() < DEPTH) rq.push_back(8'h10);
      m_flag = 3'd3;
    end else if (c == 8'h19) begin
      sub = (pq.size() > 0) ? pq.pop_front() : 8'h00;
      if (sub == 8'h20) begin
        for (int i = 0; i < 4; i++) if (rq.size() < DEPTH) rq.push_back(ver(i));
        pq.delete();
        m_flag = 3'd3;
      end
    end
  endtask

  task automatic cmd(input logic [7:0] c);
    wr(3'd1, c);
    wait_idle();
    model_cmd(c);
  endtask

  task automatic pop_chk(input logic [2:0] a, input string req);
    logic [7:0] d, e;
    rd(a, d);
    if (a == 3'd1) e = (rq.size() > 0) ? rq.pop_front() : 8'h00;
    else           e = (dq.size() > 0) ? dq.pop_front() : 8'h00;
    chk(req, d, e);
  endtask

  task automatic stat_chk(input string req);
    logic [7:0] d;
    rd(3'd0, d);
    chk(req, d, exp_status(1'b0));
  endtask

  task automatic irq_chk(input string req);
    logic [7:0] d;
    rd(3'd4, d);
    chk(req, d, {5'b0, m_flag});
    @(negedge clk);
    chk(req, {7'b0, irq}, {7'b0, exp_irq()});
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      n_cmp++;
      n_bad++;
      $display("FAIL watchdog: actual hung expected done");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    logic [7:0] d;
    host_addr = '0; host_rd = 0; host_wr = 0; host_wdata = '0;
    drv_push = 0; drv_byte = '0;
    m_flag = 3'd0; m_ien = 5'h1F;
    rst_n = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;
    repeat (4) @(posedge clk);

    // R1 reset state
    rd(3'd0, d); chk("R1 status", d, 8'h18);
    rd(3'd3, d); chk("R1 enable", d, 8'h1F);
    irq_chk("R1 flag/irq");
    pop_chk(3'd1, "R1 response empty");
    pop_chk(3'd2, "R3 data empty pop");
    stat_chk("R3 empty pop leaves status");

    // R5 status query returns drive status byte 0x10
    cmd(8'h01);
    stat_chk("R2 status after query");
    irq_chk("R5 type 3");
    pop_chk(3'd1, "R5 drive status");
    pop_chk(3'd1, "R3 empty after drain");

    // R10 acknowledge
    wr(3'd4, 8'hE0); irq_chk("R10 ack no low bits");
    wr(3'd4, 8'h02); m_flag = 3'd0; irq_chk("R10 ack clears");

    // R4 parameter queue overflow, R6 version reply, R8 busy refusal
    ppush(8'h20);
    for (int i = 0; i < 17; i++) ppush(8'hA0 + 8'(i));
    stat_chk("R4 param full");
    wr(3'd1, 8'h19);
    rd(3'd0, d); chk("R8 busy bit", d, 8'h80);
    wr(3'd1, 8'h01);
    wait_idle();
    model_cmd(8'h19);
    stat_chk("R6 param cleared");
    for (int i = 0; i < 5; i++) pop_chk(3'd1, "R6 version bytes / R8 refused");
    irq_chk("R6 type 3");

    // R9 enable masking
    wr(3'd3, 8'h04); m_ien = 5'h04;
    rd(3'd3, d); chk("R9 enable readback", d, 8'h04);
    irq_chk("R9 masked");
    wr(3'd3, 8'h01); m_ien = 5'h01; irq_chk("R9 unmasked");
    wr(3'd4, 8'h1F); m_flag = 3'd0; irq_chk("R10 ack all");

    // R7 unknown subcommand, empty param, other command
    ppush(8'h33); ppush(8'h20);
    cmd(8'h19);
    stat_chk("R7 one byte consumed");
    irq_chk("R7 no interrupt");
    pop_chk(3'd1, "R7 no response");
    cmd(8'h05); stat_chk("R7 other command");
    cmd(8'h19); pop_chk(3'd1, "R6 reply after skip");
    wr(3'd4, 8'h01); m_flag = 3'd0;
    for (int i = 0; i < 4; i++) pop_chk(3'd1, "R6 drain");
    cmd(8'h19); stat_chk("R7 empty param test"); irq_chk("R7 empty param irq");

    // R4 response and data overflow
    for (int i = 0; i < 18; i++) cmd(8'h01);
    stat_chk("R4 resp full");
    for (int i = 0; i < 17; i++) pop_chk(3'd1, "R4 resp drop");
    for (int i = 0; i < 20; i++) dpush(8'(i * 7 + 1));
    stat_chk("R4 data full");
    for (int i = 0; i < 17; i++) pop_chk(3'd2, "R3 data order");

    // random traffic
    void'($urandom(32'h5EED_0042));
    for (int it = 0; it < 1500; it++) begin
      int op;
      op = int'($urandom % 11);
      case (op)
        0, 1: ppush(($urandom % 3 == 0) ? 8'h20 : 8'($urandom));
        2:    dpush(8'($urandom));
        3:    pop_chk(3'd1, "R3 random resp");
        4:    pop_chk(3'd2, "R3 random data");
        5:    stat_chk("R2 random status");
        6:    cmd(8'h01);
        7:    cmd(8'h19);
        8:    begin
                d = 8'($urandom);
                wr(3'd4, d);
                if (|d[4:0]) m_flag = 3'd0;
                irq_chk("R10 random ack");
              end
        9:    begin
                d = 8'($urandom);
                wr(3'd3, d);
                m_ien = d[4:0];
                irq_chk("R9 random enable");
              end
        default: cmd(8'($urandom % 32));
      endcase
    end
    stat_chk("R2 final status");

    finished = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  // random commands other than 0x01/0x19 go through model_cmd, which ignores them (R7)
endmodule